// File: doc/BRIEF.md
# Single-Descriptor Buffer DMA Engine

This block moves one data buffer between system memory and the byte streams of a flash cycle sequencer. Software places a 16-byte descriptor in memory and writes its address into a base register. When the sequencer starts a data cycle, the engine reads the descriptor over a 64-bit request/response memory port. It then checks that the descriptor is handed to hardware.

If the descriptor is handed over, the engine streams the buffer. A transmit cycle reads memory beats and feeds bytes to the sequencer. A receive cycle collects bytes from the sequencer and writes memory beats. Whole 8-byte beats are always moved, even when the flash byte count is not a multiple of eight. At the end the engine rewrites the descriptor's status word with the hardware-ownership flag cleared, then pulses a completion event.

If the descriptor is still owned by software, the engine moves no data and pulses a descriptor-unavailable event instead.

Top module: `sdma_engine`

## Requirements
- R1: A configuration write at byte offset 0x18 loads the descriptor base address; writes at any other offset leave the base unchanged.
- R2: On `cyc_start` while waiting, the engine reads two beats from the base and from base+8. The status word is beat 0 bits [31:0]. The size is beat 0 bits [43:32] (the upper bits of that word are ignored). The data pointer is beat 1 bits [31:0]. Beat 1 bits [63:32] are ignored.
- R3: If status bit 31 (hardware owns) is clear, the engine pulses `evt_pulse` bit 8, issues no further memory request, moves no byte and waits for the next start.
- R4: A transmit cycle (`cyc_rx`=0) reads ceil(size/8) beats from the pointer upward in steps of 8. It presents bytes on `tx_data` in little-endian order (byte 0 = beat bits [7:0]) for the first `cyc_nbytes` byte positions only. The remaining bytes of the last beat are dropped.
- R5: A receive cycle (`cyc_rx`=1) accepts `cyc_nbytes` bytes from `rx_data` and packs them little-endian into beats. Byte positions at or beyond `cyc_nbytes` are filled with zero. Each beat is written with byte enables 0xFF from the pointer upward.
- R6: After the last beat, the engine writes the base address with byte enables 0x0F. Data bits [31:0] are the fetched status with bit 31 cleared and all other bits kept, and bits [63:32] are zero.
- R7: After the status write is granted, `evt_pulse` carries a one-cycle pulse. Bit 6 marks a transmit completion and bit 7 a receive completion. At most one event bit is ever high.
- R8: A size of zero moves no data beat; the status write and the completion pulse still follow.
- R9: A memory request holds its address, direction, enables and data until granted. Only one read is outstanding, and every address is a multiple of 8.
- R10: `cyc_start` is ignored while a cycle is in progress.
- R11: During reset no memory request, stream handshake or event is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cyc_start | input | 1 | Data cycle start pulse from the sequencer |
| cyc_rx | input | 1 | 1 = flash to memory, 0 = memory to flash |
| cyc_nbytes | input | CNT_W | Exact flash byte count of the cycle |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_be | output | 8 | Byte enables of a write |
| mem_addr | output | 32 | Byte address, 8-aligned |
| mem_wdata | output | 64 | Write data |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| tx_valid | output | 1 | Byte for the sequencer is valid |
| tx_data | output | 8 | Byte for the sequencer |
| tx_ready | input | 1 | Sequencer takes the byte |
| rx_valid | input | 1 | Byte from the sequencer is valid |
| rx_data | input | 8 | Byte from the sequencer |
| rx_ready | output | 1 | Engine takes the byte |
| evt_pulse | output | 16 | One-cycle event bits: 6 transmit done, 7 receive done, 8 descriptor unavailable |

## Verification
The checks assume a memory side that answers each read with exactly one `mem_rvalid`, no earlier than the cycle after the grant. They also assume that the base and data pointer are multiples of 8 and that `cyc_nbytes` never exceeds the descriptor size. The bench's memory model follows those rules. It varies grant stalls and read latency, while all descriptors it builds keep aligned pointers and byte counts within the size. The stream sides throttle `tx_ready` and `rx_valid` in repeating patterns, so the alignment and hold properties are exercised under back-pressure and not only at full rate.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

    localparam int ADDR_W      = 32;
    localparam int WORD_W      = 32;
    localparam int BEAT_BYTES  = 8;
    localparam int BEAT_W      = BEAT_BYTES * 8;
    localparam int BEAT_SH     = $clog2(BEAT_BYTES);
    localparam int SIZE_W      = 12;
    localparam int LEFT_W      = SIZE_W - BEAT_SH + 1;
    localparam int OWN_POS     = 31;
    localparam int EVT_W       = 16;
    localparam int EVT_TX_DONE = 6;
    localparam int EVT_RX_DONE = 7;
    localparam int EVT_NO_DESC = 8;

    localparam logic [BEAT_BYTES-1:0] BE_BEAT = '1;
    localparam logic [BEAT_BYTES-1:0] BE_WORD = BEAT_BYTES'((1 << (WORD_W / 8)) - 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH0,
        ST_WAIT0,
        ST_FETCH1,
        ST_WAIT1,
        ST_CHECK,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_TX_BYTES,
        ST_RX_BYTES,
        ST_WR_REQ,
        ST_WB_REQ
    } st_e;

    typedef struct packed {
        logic [WORD_W-1:0] status;
        logic [SIZE_W-1:0] size;
        logic [ADDR_W-1:0] ptr;
    } desc_t;

    // number of whole beats that cover a byte size
    function automatic logic [LEFT_W-1:0] beats_of(input logic [SIZE_W-1:0] sz);
        logic [SIZE_W:0] t;
        t = {1'b0, sz} + (SIZE_W + 1)'(BEAT_BYTES - 1);
        return t[SIZE_W:BEAT_SH];
    endfunction

    // status word handed back to software
    function automatic logic [WORD_W-1:0] release_own(input logic [WORD_W-1:0] s);
        logic [WORD_W-1:0] r;
        r = s;
        r[OWN_POS] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/sdma_desc.sv
module sdma_desc
    import sdma_pkg::*;
#(
    parameter int CFG_AW   = 12,
    parameter int BASE_OFS = 'h18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              cap_lo,
    input  logic              cap_hi,
    input  logic [BEAT_W-1:0] rdata,
    output logic [ADDR_W-1:0] base_o,
    output desc_t             desc_o
);

    localparam logic [CFG_AW-1:0] BASE_SEL = CFG_AW'(BASE_OFS);

    logic [ADDR_W-1:0] base_q;
    desc_t             desc_q;
    logic              unused_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            desc_q <= '0;
        end else begin
            if (cfg_we && cfg_addr == BASE_SEL)
                base_q <= ADDR_W'(cfg_wdata);
            if (cap_lo) begin
                desc_q.status <= rdata[WORD_W-1:0];
                desc_q.size   <= rdata[WORD_W +: SIZE_W];
            end
            if (cap_hi)
                desc_q.ptr <= rdata[ADDR_W-1:0];
        end
    end

    assign unused_bits = ^rdata[BEAT_W-1:WORD_W+SIZE_W];
    assign base_o      = base_q;
    assign desc_o      = desc_q;

endmodule

// File: rtl/sdma_lane.sv
module sdma_lane
    import sdma_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              is_rx,
    input  logic              run,
    input  logic              load,
    input  logic [BEAT_W-1:0] load_data,
    input  logic [CNT_W-1:0]  nbytes,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic [BEAT_W-1:0] beat_o,
    output logic              beat_done
);

    localparam int SLOT_W = BEAT_SH;
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(BEAT_BYTES - 1);

    logic [SLOT_W-1:0] slot_q;
    logic [CNT_W:0]    pos_q;
    logic [BEAT_W-1:0] beat_q;
    logic              active;
    logic              advance;

    // a byte position below the flash count carries real data
    assign active    = run && (pos_q < {1'b0, nbytes});
    assign tx_valid  = active && !is_rx;
    assign rx_ready  = active && is_rx;
    assign tx_data   = beat_q[{slot_q, 3'b000} +: 8];
    assign advance   = run && (!active || (is_rx ? rx_valid : tx_ready));
    assign beat_done = advance && (slot_q == SLOT_LAST);
    assign beat_o    = beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
            pos_q  <= '0;
            beat_q <= '0;
        end else if (clear) begin
            slot_q <= '0;
            pos_q  <= '0;
        end else if (load) begin
            beat_q <= load_data;
        end else if (advance) begin
            slot_q <= slot_q + 1'b1;
            pos_q  <= pos_q + 1'b1;
            if (is_rx)
                beat_q[{slot_q, 3'b000} +: 8] <= active ? rx_data : 8'h00;
        end
    end

endmodule

// File: rtl/sdma_fsm.sv
module sdma_fsm
    import sdma_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cyc_start,
    input  logic                  cyc_rx,
    input  logic [CNT_W-1:0]      cyc_nbytes,
    input  logic [ADDR_W-1:0]     base,
    input  desc_t                 desc,
    input  logic                  mem_gnt,
    input  logic                  mem_rvalid,
    input  logic [BEAT_W-1:0]     beat_data,
    input  logic                  beat_done,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [BEAT_BYTES-1:0] mem_be,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [BEAT_W-1:0]     mem_wdata,
    output logic                  cap_lo,
    output logic                  cap_hi,
    output logic                  lane_clear,
    output logic                  lane_run,
    output logic                  lane_load,
    output logic                  is_rx,
    output logic [CNT_W-1:0]      nbytes,
    output logic [EVT_W-1:0]      evt_pulse
);

    localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(BEAT_BYTES);
    localparam logic [LEFT_W-1:0] ONE_LEFT = LEFT_W'(1);

    st_e               st_q;
    logic              rx_q;
    logic [CNT_W-1:0]  nbytes_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [LEFT_W-1:0] left_q;
    logic [EVT_W-1:0]  evt_q;
    logic [LEFT_W-1:0] beats;

    assign beats     = beats_of(desc.size);
    assign is_rx     = rx_q;
    assign nbytes    = nbytes_q;
    assign evt_pulse = evt_q;

    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_be     = '0;
        mem_addr   = ptr_q;
        mem_wdata  = '0;
        cap_lo     = 1'b0;
        cap_hi     = 1'b0;
        lane_clear = 1'b0;
        lane_run   = 1'b0;
        lane_load  = 1'b0;
        case (st_q)
            ST_FETCH0: begin
                mem_req  = 1'b1;
                mem_addr = base;
            end
            ST_WAIT0:  cap_lo = mem_rvalid;
            ST_FETCH1: begin
                mem_req  = 1'b1;
                mem_addr = base + STEP;
            end
            ST_WAIT1:  cap_hi = mem_rvalid;
            ST_CHECK:  lane_clear = 1'b1;
            ST_RD_REQ: mem_req = 1'b1;
            ST_RD_WAIT: lane_load = mem_rvalid;
            ST_TX_BYTES, ST_RX_BYTES: lane_run = 1'b1;
            ST_WR_REQ: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_be    = BE_BEAT;
                mem_wdata = beat_data;
            end
            ST_WB_REQ: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_be    = BE_WORD;
                mem_addr  = base;
                mem_wdata = {{(BEAT_W - WORD_W){1'b0}}, release_own(desc.status)};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            rx_q     <= 1'b0;
            nbytes_q <= '0;
            ptr_q    <= '0;
            left_q   <= '0;
            evt_q    <= '0;
        end else begin
            evt_q <= '0;
            case (st_q)
                ST_IDLE: if (cyc_start) begin
                    rx_q     <= cyc_rx;
                    nbytes_q <= cyc_nbytes;
                    st_q     <= ST_FETCH0;
                end
                ST_FETCH0: if (mem_gnt)    st_q <= ST_WAIT0;
                ST_WAIT0:  if (mem_rvalid) st_q <= ST_FETCH1;
                ST_FETCH1: if (mem_gnt)    st_q <= ST_WAIT1;
                ST_WAIT1:  if (mem_rvalid) st_q <= ST_CHECK;
                ST_CHECK: begin
                    if (!desc.status[OWN_POS]) begin
                        evt_q[EVT_NO_DESC] <= 1'b1;
                        st_q <= ST_IDLE;
                    end else begin
                        ptr_q  <= desc.ptr;
                        left_q <= beats;
                        if (beats == '0)
                            st_q <= ST_WB_REQ;
                        else
                            st_q <= rx_q ? ST_RX_BYTES : ST_RD_REQ;
                    end
                end
                ST_RD_REQ:  if (mem_gnt)    st_q <= ST_RD_WAIT;
                ST_RD_WAIT: if (mem_rvalid) st_q <= ST_TX_BYTES;
                ST_TX_BYTES: if (beat_done) begin
                    ptr_q  <= ptr_q + STEP;
                    left_q <= left_q - 1'b1;
                    st_q   <= (left_q == ONE_LEFT) ? ST_WB_REQ : ST_RD_REQ;
                end
                ST_RX_BYTES: if (beat_done) st_q <= ST_WR_REQ;
                ST_WR_REQ: if (mem_gnt) begin
                    ptr_q  <= ptr_q + STEP;
                    left_q <= left_q - 1'b1;
                    st_q   <= (left_q == ONE_LEFT) ? ST_WB_REQ : ST_RX_BYTES;
                end
                ST_WB_REQ: if (mem_gnt) begin
                    if (rx_q) evt_q[EVT_RX_DONE] <= 1'b1;
                    else      evt_q[EVT_TX_DONE] <= 1'b1;
                    st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
    import sdma_pkg::*;
#(
    parameter int CFG_AW   = 12,
    parameter int BASE_OFS = 'h18,
    parameter int CNT_W    = SIZE_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [CFG_AW-1:0]     cfg_addr,
    input  logic [WORD_W-1:0]     cfg_wdata,
    input  logic                  cyc_start,
    input  logic                  cyc_rx,
    input  logic [CNT_W-1:0]      cyc_nbytes,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [BEAT_BYTES-1:0] mem_be,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [BEAT_W-1:0]     mem_wdata,
    input  logic                  mem_gnt,
    input  logic                  mem_rvalid,
    input  logic [BEAT_W-1:0]     mem_rdata,
    output logic                  tx_valid,
    output logic [7:0]            tx_data,
    input  logic                  tx_ready,
    input  logic                  rx_valid,
    input  logic [7:0]            rx_data,
    output logic                  rx_ready,
    output logic [EVT_W-1:0]      evt_pulse
);

    logic [ADDR_W-1:0] base;
    desc_t             desc;
    logic              cap_lo, cap_hi;
    logic              lane_clear, lane_run, lane_load, is_rx;
    logic [CNT_W-1:0]  nbytes;
    logic [BEAT_W-1:0] beat_data;
    logic              beat_done;

    sdma_desc #(.CFG_AW(CFG_AW), .BASE_OFS(BASE_OFS)) u_desc (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cap_lo(cap_lo), .cap_hi(cap_hi), .rdata(mem_rdata),
        .base_o(base), .desc_o(desc)
    );

    sdma_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst(rst),
        .cyc_start(cyc_start), .cyc_rx(cyc_rx), .cyc_nbytes(cyc_nbytes),
        .base(base), .desc(desc),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .beat_data(beat_data), .beat_done(beat_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .cap_lo(cap_lo), .cap_hi(cap_hi),
        .lane_clear(lane_clear), .lane_run(lane_run), .lane_load(lane_load),
        .is_rx(is_rx), .nbytes(nbytes), .evt_pulse(evt_pulse)
    );

    sdma_lane #(.CNT_W(CNT_W)) u_lane (
        .clk(clk), .rst(rst),
        .clear(lane_clear), .is_rx(is_rx), .run(lane_run),
        .load(lane_load), .load_data(mem_rdata), .nbytes(nbytes),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .beat_o(beat_data), .beat_done(beat_done)
    );

endmodule

// File: rtl/sdma_chk.sv
module sdma_chk
    import sdma_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  mem_req,
    input logic                  mem_we,
    input logic [BEAT_BYTES-1:0] mem_be,
    input logic [ADDR_W-1:0]     mem_addr,
    input logic [BEAT_W-1:0]     mem_wdata,
    input logic                  mem_gnt,
    input logic                  tx_valid,
    input logic                  rx_ready,
    input logic [EVT_W-1:0]      evt_pulse
);

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_be) && $stable(mem_wdata));

    // R9
    addr_align_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_addr[BEAT_SH-1:0] == '0);

    // R6
    own_release_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we && mem_be == BE_WORD
            |-> !mem_wdata[OWN_POS] && mem_wdata[BEAT_W-1:WORD_W] == '0);

    // R7
    evt_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(evt_pulse));

    // R7
    done_after_wb_chk: assert property (@(posedge clk) disable iff (rst)
        evt_pulse[EVT_TX_DONE] || evt_pulse[EVT_RX_DONE]
            |-> $past(mem_req && mem_we && mem_gnt && mem_be == BE_WORD));

    // R5
    stream_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(tx_valid && rx_ready));

endmodule

bind sdma_engine sdma_chk u_chk (
    .clk(clk), .rst(rst),
    .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .tx_valid(tx_valid), .rx_ready(rx_ready), .evt_pulse(evt_pulse)
);

// File: tb/sdma_engine_tb.sv
module sdma_engine_tb;
    import sdma_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cyc_start = 1'b0;
    logic        cyc_rx = 1'b0;
    logic [11:0] cyc_nbytes = '0;
    logic        mem_req, mem_we;
    logic [7:0]  mem_be;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic [15:0] evt_pulse;

    always #4 clk = ~clk;

    sdma_engine u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cyc_start(cyc_start), .cyc_rx(cyc_rx), .cyc_nbytes(cyc_nbytes),
        .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .evt_pulse(evt_pulse)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [7:0]  be;
        logic [63:0] data;
    } wr_t;

    logic [63:0] mem [0:63];
    wr_t         exp_wr[$];
    logic [7:0]  exp_tx[$];
    logic [7:0]  rx_src[$];
    logic [15:0] exp_evt[$];
    int          checks = 0;
    int          fails = 0;
    int          rd_count = 0;
    int          stall_sel = 0;
    logic [31:0] cur_base = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory model: grants after a stall, answers reads one or two cycles later
    initial begin : mem_model
        int stall_cnt;
        int rd_pend;
        int rd_idx;
        stall_cnt = 0;
        rd_pend = 0;
        rd_idx = 0;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (rd_pend > 0) begin
                rd_pend--;
                if (rd_pend == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = mem[rd_idx];
                end
            end
            if (mem_gnt) begin
                mem_gnt = 1'b0;
            end else if (mem_req && !rst) begin
                if (stall_cnt < stall_sel) begin
                    stall_cnt++;
                end else begin
                    stall_cnt = 0;
                    mem_gnt = 1'b1;
                    if (mem_we) begin
                        if (exp_wr.size() == 0) begin
                            chk(1'b0, "R3", "unexpected write addr", 64'(mem_addr), 64'h0);
                        end else begin
                            wr_t e;
                            e = exp_wr.pop_front();
                            chk(mem_addr == e.addr, (e.be == 8'h0F) ? "R6" : "R5",
                                "write address", 64'(mem_addr), 64'(e.addr));
                            chk(mem_be == e.be, (e.be == 8'h0F) ? "R6" : "R5",
                                "write enables", 64'(mem_be), 64'(e.be));
                            chk(mem_wdata == e.data, (e.be == 8'h0F) ? "R6" : "R5",
                                "write data", mem_wdata, e.data);
                        end
                        for (int b = 0; b < 8; b++)
                            if (mem_be[b]) mem[mem_addr[8:3]][b*8 +: 8] = mem_wdata[b*8 +: 8];
                    end else begin
                        rd_count++;
                        rd_idx  = int'(mem_addr[8:3]);
                        rd_pend = 1 + (stall_sel % 2);
                    end
                end
            end
        end
    end

    // stream side: throttled ready/valid, transmit monitor compares bytes
    initial begin : stream_model
        int phase;
        phase = 0;
        forever begin
            @(negedge clk);
            phase++;
            tx_ready = (phase % 3) != 1;
            if (tx_valid && tx_ready) begin
                if (exp_tx.size() == 0)
                    chk(1'b0, "R4", "unexpected tx byte", 64'(tx_data), 64'h0);
                else begin
                    logic [7:0] eb;
                    eb = exp_tx.pop_front();
                    chk(tx_data == eb, "R4", "tx byte", 64'(tx_data), 64'(eb));
                end
            end
            rx_valid = (rx_src.size() > 0) && ((phase % 4) != 2);
            rx_data  = rx_valid ? rx_src[0] : 8'h00;
            if (rx_valid && rx_ready) void'(rx_src.pop_front());
        end
    end

    // event monitor
    initial begin : evt_model
        forever begin
            @(negedge clk);
            if (!rst && evt_pulse != '0) begin
                if (exp_evt.size() == 0)
                    chk(1'b0, "R7", "unexpected event", 64'(evt_pulse), 64'h0);
                else begin
                    logic [15:0] ee;
                    ee = exp_evt.pop_front();
                    chk(evt_pulse == ee, ee[8] ? "R3" : "R7", "event bits",
                        64'(evt_pulse), 64'(ee));
                end
            end
        end
    end

    task automatic cfg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // driver: builds descriptor and data, pushes expectations, starts the cycle
    task automatic xfer(input bit rx, input int nbytes, input logic [31:0] status,
                        input int size, input logic [31:0] ptr, input logic [31:0] w3,
                        input bit poke_busy, input string tag);
        int bidx;
        int pidx;
        int beats;
        int t;
        bit own;
        bidx  = int'(cur_base[8:3]);
        pidx  = int'(ptr[8:3]);
        beats = (size + 7) / 8;
        own   = status[31];
        mem[bidx]     = {32'hABC0_0000 | 32'(size), status};
        mem[bidx + 1] = {w3, ptr};
        if (!own) begin
            exp_evt.push_back(16'h0100);
        end else begin
            if (rx) begin
                for (int i = 0; i < nbytes; i++) rx_src.push_back(8'(8'h41 + 8'(i * 3)));
                for (int k = 0; k < beats; k++) begin
                    wr_t w;
                    w.addr = ptr + 32'(k * 8);
                    w.be   = 8'hFF;
                    for (int b = 0; b < 8; b++)
                        w.data[b*8 +: 8] = (k * 8 + b < nbytes) ? 8'(8'h41 + 8'((k * 8 + b) * 3)) : 8'h00;
                    exp_wr.push_back(w);
                end
            end else begin
                for (int k = 0; k < beats; k++)
                    for (int b = 0; b < 8; b++)
                        mem[pidx + k][b*8 +: 8] = 8'(8'h11 + 8'((k * 8 + b) * 5));
                for (int i = 0; i < nbytes && i < beats * 8; i++)
                    exp_tx.push_back(mem[pidx + i / 8][(i % 8) * 8 +: 8]);
            end
            begin
                wr_t wb;
                wb.addr = cur_base;
                wb.be   = 8'h0F;
                wb.data = {32'h0, status & 32'h7FFF_FFFF};
                exp_wr.push_back(wb);
            end
            exp_evt.push_back(rx ? 16'h0080 : 16'h0040);
        end
        rd_count = 0;
        @(negedge clk);
        cyc_rx = rx; cyc_nbytes = 12'(nbytes); cyc_start = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
        if (poke_busy) begin
            repeat (6) @(negedge clk);
            cyc_rx = !rx; cyc_start = 1'b1;
            @(negedge clk);
            cyc_start = 1'b0;
        end
        t = 0;
        while (exp_evt.size() > 0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (8) @(negedge clk);
        chk(exp_evt.size() == 0, "R7", {tag, " events left"}, 64'(exp_evt.size()), 64'h0);
        chk(exp_tx.size() == 0, "R4", {tag, " tx bytes left"}, 64'(exp_tx.size()), 64'h0);
        chk(exp_wr.size() == 0, rx ? "R5" : "R6", {tag, " writes left"}, 64'(exp_wr.size()), 64'h0);
        chk(rx_src.size() == 0, "R5", {tag, " rx bytes left"}, 64'(rx_src.size()), 64'h0);
        chk(rd_count == 2 + ((own && !rx) ? beats : 0), "R2", {tag, " read count"},
            64'(rd_count), 64'(2 + ((own && !rx) ? beats : 0)));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 64; i++) mem[i] = 64'hDEAD_BEEF_0BAD_F00D;
        repeat (4) @(negedge clk);
        // R11 reset state
        chk(mem_req == 1'b0, "R11", "mem_req in reset", 64'(mem_req), 64'h0);
        chk(evt_pulse == '0, "R11", "evt in reset", 64'(evt_pulse), 64'h0);
        chk(tx_valid == 1'b0 && rx_ready == 1'b0, "R11", "stream in reset",
            64'({tx_valid, rx_ready}), 64'h0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1 base load, then a write at another offset that must not move it
        cfg_write(12'h018, 32'h0000_0040);
        cfg_write(12'h01C, 32'h0000_0100);
        cur_base = 32'h40;

        stall_sel = 0;
        xfer(1'b0, 13, 32'h8000_000C, 16, 32'h80, 32'h0, 1'b0, "R1 R4 tx13");
        stall_sel = 1;
        xfer(1'b1, 5, 32'h8010_000C, 8, 32'h100, 32'h0, 1'b0, "R5 rx5");
        stall_sel = 2;
        xfer(1'b1, 16, 32'h8050_000C, 16, 32'h100, 32'h1234_5678, 1'b0, "R2 rx16");
        stall_sel = 1;
        xfer(1'b0, 24, 32'h8000_000C, 24, 32'h80, 32'hFFFF_FFF0, 1'b1, "R10 tx24 busy");
        stall_sel = 0;
        xfer(1'b0, 16, 32'h0000_000C, 16, 32'h80, 32'h0, 1'b0, "R3 own clear");
        xfer(1'b0, 0, 32'h8000_000C, 0, 32'h80, 32'h0, 1'b0, "R8 tx size0");
        xfer(1'b1, 0, 32'h8000_000C, 0, 32'h100, 32'h0, 1'b0, "R8 rx size0");

        // R1 move the base
        cfg_write(12'h018, 32'h0000_00C0);
        cur_base = 32'hC0;
        stall_sel = 3;
        xfer(1'b0, 1, 32'h8000_000C, 8, 32'h80, 32'h0, 1'b0, "R1 new base tx1");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule